// File: doc/BRIEF.md
# Dual Pattern Serial Detector

This block watches a one-bit serial stream that is sampled on every rising clock edge. It raises a one-bit flag when the most recent input history matches either of two patterns. The first pattern is a three-bit run of one, zero, one, read from oldest to newest. The second is a pair of consecutive ones. Matches may share bits with one another, so a single stream can raise the flag on several cycles in a row.

The block is a Moore machine with five states. Each state records only as much history as the two patterns need. The flag is decoded from the state register alone, so it shows the result for a bit in the cycle after that bit is sampled. A change on the serial input can never reach the flag within the same cycle.

The reset input is active low. It clears the machine at once, without waiting for a clock edge. Its release is passed through a two-stage synchroniser. Once the release has gone through, the machine treats all earlier history as zeros.

Top module: `dual_pattern_det`

## Requirements
- R1: While `rst_n` is low, `match_o` is 0. After `rst_n` returns high and the two-edge release delay has passed, `match_o` stays 0 as long as only zeros are applied.
- R2: When the last three sampled bits are 1, 0, 1 (oldest first), `match_o` is 1 in the cycle that follows the edge that sampled the final 1.
- R3: When the last two sampled bits are both 1, `match_o` is 1 in the cycle that follows the edge that sampled the second 1.
- R4: In every other case `match_o` is 0. In particular, whenever the newest sampled bit is 0, `match_o` is 0 in the following cycle.
- R5: Matches overlap. The stream 1,0,1,1 raises `match_o` after the third bit and again after the fourth. A run of N ones raises it after every one of them except the first.
- R6: `match_o` changes only at a rising clock edge or on reset assertion. Toggling `ser_in` in the middle of a cycle leaves it unchanged.
- R7: Reset discards history. A 1 or a 0,1 sampled after reset release counts as if the bits before it were 0.
- R8: The first bit sampled is the one present at the third rising edge after `rst_n` goes high. Bits at the two earlier edges are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the input is sampled on the rising edge |
| rst_n | input | 1 | Active-low reset; asserts at once, release is synchronised |
| ser_in | input | 1 | Serial data bit |
| match_o | output | 1 | High when the recent history matches 1,0,1 or 1,1 |

## Verification
The bench aims at the overlap between the two patterns (1,0,1,1 and long runs of ones). A design that consumed the history on a match would drop the second flag. It also checks 1,0,1 followed directly by 0,1, which a machine that forgot the middle zero would flag too early or not at all. Mid-cycle toggles of the input catch a Mealy-style leak, where the flag would follow `ser_in` within the cycle. A reset in the middle of a run of ones catches stale history: a design that kept the old bits would flag the first 1 sampled after release.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  // Each state holds only the history the two patterns can still use.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,  // newest bit 0, nothing pending (or no history)
    ST_ONE    = 3'd1,  // newest bit 1, previous two not matching
    ST_GAP    = 3'd2,  // 1 then 0: one bit away from a triple hit
    ST_TRIPLE = 3'd3,  // 1,0,1 just completed
    ST_PAIR   = 3'd4   // 1,1 just completed
  } dpd_state_t;
endpackage

// File: rtl/dpd_rst_sync.sv
module dpd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dpd_next.sv
module dpd_next
  import dpd_pkg::*;
(
  input  dpd_state_t cur_st,
  input  logic       bit_in,
  output dpd_state_t nxt_st
);
  always_comb begin
    case (cur_st)
      ST_IDLE:   nxt_st = bit_in ? ST_ONE    : ST_IDLE;
      ST_ONE:    nxt_st = bit_in ? ST_PAIR   : ST_GAP;
      ST_GAP:    nxt_st = bit_in ? ST_TRIPLE : ST_IDLE;
      ST_TRIPLE: nxt_st = bit_in ? ST_PAIR   : ST_GAP;
      ST_PAIR:   nxt_st = bit_in ? ST_PAIR   : ST_GAP;
      default:   nxt_st = ST_IDLE;  // illegal code: fall back to no history
    endcase
  end
endmodule

// File: rtl/dpd_out.sv
module dpd_out
  import dpd_pkg::*;
(
  input  dpd_state_t cur_st,
  output logic       hit
);
  always_comb begin
    case (cur_st)
      ST_TRIPLE, ST_PAIR: hit = 1'b1;
      default:            hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dual_pattern_det.sv
module dual_pattern_det
  import dpd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  output logic match_o
);
  logic       rst_sync_n;
  dpd_state_t state_q;
  dpd_state_t state_d;

  dpd_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dpd_next u_next (
    .cur_st (state_q),
    .bit_in (ser_in),
    .nxt_st (state_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  dpd_out u_out (
    .cur_st (state_q),
    .hit    (match_o)
  );

  // R1: flag low whenever the internal reset is active
  p_reset_low_r1: assert property (@(posedge clk) !rst_sync_n |-> !match_o)
    else $error("p_reset_low_r1");

  // R3: two sampled ones in a row raise the flag next cycle
  p_pair_hit_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ser_in && $past(ser_in) && $past(rst_sync_n)) |=> match_o)
    else $error("p_pair_hit_r3");

  // R2: 1,0,1 raises the flag next cycle
  p_triple_hit_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ser_in && !$past(ser_in) && $past(ser_in, 2) &&
       $past(rst_sync_n) && $past(rst_sync_n, 2)) |=> match_o)
    else $error("p_triple_hit_r2");

  // R4: a sampled zero always clears the flag next cycle
  p_zero_clears_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !ser_in |=> !match_o)
    else $error("p_zero_clears_r4");

  // R4: a lone one after two zeros does not raise the flag
  p_lone_one_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ser_in && !$past(ser_in) && !$past(ser_in, 2) &&
       $past(rst_sync_n) && $past(rst_sync_n, 2)) |=> !match_o)
    else $error("p_lone_one_r4");
endmodule

// File: tb/dual_pattern_det_tb_top.sv
`timescale 1ns/100ps
module dual_pattern_det_tb_top;
  logic clk;
  logic rst_n;
  logic ser_in;
  logic match_o;

  int checks;
  int failures;
  int cycles;
  bit done;
  logic [2:0] hist;
  bit    exp_q[$];
  string tag_q[$];

  dual_pattern_det dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .match_o (match_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: match_o=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: apply one bit and push the expected flag for the next cycle.
  task automatic drive_bit(input logic b);
    string tag;
    @(negedge clk);
    ser_in = b;
    hist = {hist[1:0], b};
    if (hist[1:0] == 2'b11) tag = "R3";
    else if (hist == 3'b101) tag = "R2";
    else tag = "R4";
    exp_q.push_back((hist == 3'b101) || (hist[1:0] == 2'b11));
    tag_q.push_back(tag);
  endtask

  task automatic drive_tagged(input logic b, input string tag);
    drive_bit(b);
    void'(tag_q.pop_back());
    tag_q.push_back(tag);
  endtask

  // Monitor: pop and compare just after each rising edge.
  always @(posedge clk) begin
    #0.2;
    if (exp_q.size() > 0) begin
      check(match_o, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ser_in = 1'b1;
    #0.4;
    check(match_o, 1'b0, "R1 reset asserted");
    repeat (2) @(negedge clk);
    check(match_o, 1'b0, "R1 held in reset");
    rst_n = 1'b1;
    hist = 3'b000;
    // R8: ones during the release delay are ignored
    @(negedge clk);
    ser_in = 1'b1;
    @(negedge clk);
    ser_in = 1'b0;
    check(match_o, 1'b0, "R8 release window ignored");
  endtask

  task automatic moore_probe(input string req);
    logic held;
    @(posedge clk);
    #0.4;
    held = match_o;
    ser_in = ~ser_in;
    #0.4;
    check(match_o, held, req);
    ser_in = ~ser_in;
    #0.4;
    check(match_o, held, req);
  endtask

  initial begin
    done = 1'b0;
    checks = 0;
    failures = 0;
    hist = 3'b000;
    rst_n = 1'b0;
    ser_in = 1'b0;
    do_reset();
    repeat (3) drive_tagged(1'b0, "R1 idle zeros");

    // R2 then R4 lone patterns
    drive_tagged(1'b1, "R7 first one");
    drive_tagged(1'b0, "R4 gap");
    drive_tagged(1'b1, "R2 triple");
    drive_tagged(1'b0, "R4 zero after hit");
    drive_tagged(1'b0, "R4 double zero");
    // R5 overlap 1,0,1,1
    drive_tagged(1'b1, "R5 start");
    drive_tagged(1'b0, "R5 gap");
    drive_tagged(1'b1, "R5 triple");
    drive_tagged(1'b1, "R5 pair overlap");
    drive_tagged(1'b1, "R5 run");
    moore_probe("R6 mid-cycle toggle while high");
    drive_tagged(1'b1, "R5 run");
    drive_tagged(1'b0, "R4 run end");
    moore_probe("R6 mid-cycle toggle while low");
    // 1,0,1,0,1 chained triples
    drive_tagged(1'b1, "R2 chain");
    drive_tagged(1'b0, "R2 chain gap");
    drive_tagged(1'b1, "R2 chain hit1");
    drive_tagged(1'b0, "R2 chain gap");
    drive_tagged(1'b1, "R2 chain hit2");
    drive_tagged(1'b1, "R3 pair");

    // R7 reset in the middle of a run of ones
    @(posedge clk);
    #0.4;
    do_reset();
    drive_tagged(1'b1, "R7 one after reset");
    drive_tagged(1'b0, "R7 zero");
    drive_tagged(1'b1, "R7 triple after reset");
    drive_tagged(1'b0, "R4 zero");
    drive_tagged(1'b0, "R4 zero");
    drive_tagged(1'b0, "R7 clear");
    do_reset();
    drive_tagged(1'b0, "R7 zero first");
    drive_tagged(1'b1, "R7 zero-one only");

    // Random stream
    for (int i = 0; i < 3000; i++) begin
      drive_bit(1'($urandom_range(0, 1)));
    end
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: cycles=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule